// File: doc/BRIEF.md
# Extended-Precision Floating-Point Multiplier

This block multiplies two floating-point numbers held in a 44-bit extended word. From the most significant bit down, a word is a sign bit, an 11-bit biased exponent, an explicit integer bit and a 31-bit fraction. The integer bit and the fraction together form a 32-bit mantissa. The two mantissas are multiplied into a full 64-bit product. The exponents are added and the bias of 1023 is taken off once. The product is then normalized and rounded to nearest-even. Each operation chooses its rounding width: all 32 mantissa bits (extended mode) or the top 24 bits (single mode, low 8 mantissa bits cleared). Both widths are rounded from the same 64-bit product.

Results outside the finite exponent range do not wrap. Exponents that are too small flush to a signed zero and raise the underflow flag. Exponents that are too large saturate to the largest finite magnitude and raise the overflow flag. An operand coming from a longer source format is expected to arrive with its fraction already cut to 31 bits. The datapath has one register stage: a result appears one clock after its request, and the output register holds its contents between requests.

Top module: `fpx_mul`

## Requirements
- R1: The result sign (bit 43) is the XOR of the operand signs (bit 43 of each operand). The result keeps the layout sign[43], exponent[42:32], integer bit[31], fraction[30:0].
- R2: When the 64-bit mantissa product is below 2.0 (product bit 63 clear), the product is shifted left by one. The result exponent is then exp_a + exp_b − 1023.
- R3: When the mantissa product is 2.0 or more (product bit 63 set), the result exponent is exp_a + exp_b − 1022. The mantissa is taken from product bits 63 downward.
- R4: With `prec_single` = 0, the mantissa is the top 32 bits of the normalized product, rounded to nearest with ties to even. The guard bit is the next bit down, and all bits below it form the sticky bit.
- R5: With `prec_single` = 1, the top 24 bits of the normalized product are rounded to nearest-even in the same way and placed in result bits [31:8]; result bits [7:0] are zero.
- R6: A rounding carry out of the kept mantissa gives a mantissa of 1.0 (only the integer bit set) and increments the exponent by one.
- R7: When the final exponent is below 1, the result is a zero carrying the R1 sign (exponent and mantissa all zero), and `underflow` is 1.
- R8: When the final exponent exceeds 2046, the exponent is 2046 and the mantissa is all ones in the kept width, and `overflow` is 1. `underflow` and `overflow` are never 1 together.
- R9: When either operand's 32-bit mantissa is zero, the result is a zero carrying the R1 sign, with both flags 0, whatever the exponents are.
- R10: `out_valid` is `in_valid` delayed by one clock. While `in_valid` is 0, `result`, `underflow` and `overflow` keep their values.
- R11: Under reset (`rst_n` = 0), `out_valid`, `result`, `underflow` and `overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and precision are valid this cycle |
| op_a | input | 44 | First operand, extended format |
| op_b | input | 44 | Second operand, extended format |
| prec_single | input | 1 | 1: round to 24-bit mantissa; 0: round to 32-bit mantissa |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| result | output | 44 | Product, extended format |
| underflow | output | 1 | Result was flushed to zero |
| overflow | output | 1 | Result was saturated |

## Verification
The bench drives two instances with the same stimulus. One uses the default widths (11-bit exponent, 31-bit fraction, 24-bit narrow mantissa). The other narrows the single-mode mantissa to 16 bits. This moves the guard and sticky positions and checks that the rounding lanes follow the parameter rather than fixed bit positions. Operands include exponents near both ends of the range, mantissas with low bits cleared to create exact ties, and all-ones mantissas that force rounding carries. These reach flush, saturation, the exponent boundaries at 1 and 2046, and renormalization after rounding, in both precisions.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

   // rounding precision selected per operation
   typedef enum logic {
      PREC_EXT = 1'b0,
      PREC_SGL = 1'b1
   } prec_e;

   // index of each rounding lane in the generated lane array
   localparam int LANE_EXT = 0;
   localparam int LANE_SGL = 1;
   localparam int LANE_CNT = 2;

endpackage

// File: rtl/fpx_mant_mul.sv
module fpx_mant_mul #(
   parameter int MANT_W = 32
) (
   input  logic [MANT_W-1:0]   mant_a,
   input  logic [MANT_W-1:0]   mant_b,
   output logic [2*MANT_W-1:0] norm,
   output logic                hi_shift
);
   localparam int PROD_W = 2 * MANT_W;

   logic [PROD_W-1:0] prod;

   assign prod     = PROD_W'(mant_a) * PROD_W'(mant_b);
   assign hi_shift = prod[PROD_W-1];

   // bring the integer bit to the top of the product
   always_comb begin
      if (hi_shift) begin
         norm = prod;
      end else begin
         norm = {prod[PROD_W-2:0], 1'b0};
      end
   end

   // R2 R3: two operands with integer bits set always give a top bit set after normalization
   always_comb begin
      if (mant_a[MANT_W-1] && mant_b[MANT_W-1]) begin
         a_r3_norm_top : assert (norm[PROD_W-1]);
      end
   end

endmodule

// File: rtl/fpx_round.sv
module fpx_round #(
   parameter int MANT_W = 32,
   parameter int KEEP_W = 24
) (
   input  logic [2*MANT_W-1:0] norm,
   output logic [MANT_W-1:0]   mant,
   output logic                carry
);
   localparam int PROD_W = 2 * MANT_W;
   localparam int PAD_W  = MANT_W - KEEP_W;

   if (KEEP_W < 2 || KEEP_W > MANT_W) begin : g_bad_keep
      $error("fpx_round: KEEP_W must lie in 2..MANT_W");
   end

   logic [KEEP_W-1:0] hi;
   logic              guard;
   logic              sticky;
   logic              inc;
   logic [KEEP_W:0]   sum;
   logic [KEEP_W-1:0] kept;

   assign hi     = norm[PROD_W-1 -: KEEP_W];
   assign guard  = norm[PROD_W-1-KEEP_W];
   assign sticky = |norm[PROD_W-2-KEEP_W:0];
   // nearest, ties to the even kept value
   assign inc    = guard & (sticky | hi[0]);
   assign sum    = {1'b0, hi} + (KEEP_W+1)'(inc);
   assign carry  = sum[KEEP_W];

   always_comb begin
      if (carry) begin
         kept = {1'b1, {(KEEP_W-1){1'b0}}};
      end else begin
         kept = sum[KEEP_W-1:0];
      end
   end

   if (PAD_W == 0) begin : g_full
      assign mant = kept;
   end else begin : g_pad
      assign mant = {kept, {PAD_W{1'b0}}};
   end

   // R6: a carry is only possible from an all-ones kept field
   always_comb begin
      if (carry) begin
         a_r6_carry_from_ones : assert (&hi);
      end
   end

endmodule

// File: rtl/fpx_range.sv
module fpx_range #(
   parameter int EXP_W    = 11,
   parameter int MANT_W   = 32,
   parameter int NARROW_W = 24
) (
   input  logic                    sign_i,
   input  logic [EXP_W+1:0]        exp_i,
   input  logic [MANT_W-1:0]       mant_i,
   input  logic                    narrow_i,
   input  logic                    zero_i,
   output logic [EXP_W+MANT_W:0]   word_o,
   output logic                    uf_o,
   output logic                    ov_o
);
   localparam int EXT_W = EXP_W + 2;
   localparam logic [EXP_W-1:0]  EMAX_F   = {{(EXP_W-1){1'b1}}, 1'b0};
   localparam logic [EXT_W-1:0]  EMAX_X   = {2'b00, EMAX_F};
   localparam logic [MANT_W-1:0] SAT_WIDE = '1;
   localparam logic [MANT_W-1:0] SAT_NARR = {{NARROW_W{1'b1}}, {(MANT_W-NARROW_W){1'b0}}};

   logic too_low;
   logic too_high;

   assign too_low  = $signed(exp_i) < $signed(EXT_W'(1));
   assign too_high = $signed(exp_i) > $signed(EMAX_X);

   always_comb begin
      uf_o   = 1'b0;
      ov_o   = 1'b0;
      word_o = {sign_i, exp_i[EXP_W-1:0], mant_i};
      if (zero_i) begin
         word_o = {sign_i, {(EXP_W+MANT_W){1'b0}}};
      end else if (too_low) begin
         word_o = {sign_i, {(EXP_W+MANT_W){1'b0}}};
         uf_o   = 1'b1;
      end else if (too_high) begin
         word_o = {sign_i, EMAX_F, narrow_i ? SAT_NARR : SAT_WIDE};
         ov_o   = 1'b1;
      end
   end

   // R8: the two range flags exclude each other
   always_comb begin
      a_r8_flags_exclusive : assert (!(uf_o && ov_o));
   end

endmodule

// File: rtl/fpx_mul.sv
module fpx_mul #(
   parameter int EXP_W    = 11,
   parameter int FRAC_W   = 31,
   parameter int NARROW_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [EXP_W+FRAC_W+1:0] op_a,
   input  logic [EXP_W+FRAC_W+1:0] op_b,
   input  logic                    prec_single,
   output logic                    out_valid,
   output logic [EXP_W+FRAC_W+1:0] result,
   output logic                    underflow,
   output logic                    overflow
);
   import fpx_pkg::*;

   localparam int MANT_W = FRAC_W + 1;
   localparam int WORD_W = 1 + EXP_W + MANT_W;
   localparam int EXT_W  = EXP_W + 2;
   localparam int PROD_W = 2 * MANT_W;
   localparam int BIAS   = (2 ** (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] EMAX_F = {{(EXP_W-1){1'b1}}, 1'b0};

   if (EXP_W < 3 || EXP_W > 15) begin : g_bad_exp
      $error("fpx_mul: EXP_W must lie in 3..15");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("fpx_mul: FRAC_W must be at least 2");
   end
   if (NARROW_W < 2 || NARROW_W >= MANT_W) begin : g_bad_narrow
      $error("fpx_mul: NARROW_W must lie in 2..MANT_W-1");
   end

   // operand fields
   logic              a_sign, b_sign;
   logic [EXP_W-1:0]  a_exp, b_exp;
   logic [MANT_W-1:0] a_mant, b_mant;
   logic              zero_in;
   prec_e             prec;

   assign a_sign  = op_a[WORD_W-1];
   assign b_sign  = op_b[WORD_W-1];
   assign a_exp   = op_a[WORD_W-2 -: EXP_W];
   assign b_exp   = op_b[WORD_W-2 -: EXP_W];
   assign a_mant  = op_a[MANT_W-1:0];
   assign b_mant  = op_b[MANT_W-1:0];
   assign zero_in = (a_mant == '0) || (b_mant == '0);
   assign prec    = prec_e'(prec_single);

   // mantissa product
   logic [PROD_W-1:0] prod_norm;
   logic              prod_shift;

   fpx_mant_mul #(
      .MANT_W (MANT_W)
   ) u_mant_mul (
      .mant_a   (a_mant),
      .mant_b   (b_mant),
      .norm     (prod_norm),
      .hi_shift (prod_shift)
   );

   // one rounding lane per precision
   logic [LANE_CNT-1:0][MANT_W-1:0] lane_mant;
   logic [LANE_CNT-1:0]             lane_carry;

   for (genvar gi = 0; gi < LANE_CNT; gi++) begin : g_lane
      localparam int KW = (gi == LANE_SGL) ? NARROW_W : MANT_W;
      fpx_round #(
         .MANT_W (MANT_W),
         .KEEP_W (KW)
      ) u_round (
         .norm  (prod_norm),
         .mant  (lane_mant[gi]),
         .carry (lane_carry[gi])
      );
   end

   logic [MANT_W-1:0] rnd_mant;
   logic              rnd_carry;

   assign rnd_mant  = (prec == PREC_SGL) ? lane_mant[LANE_SGL]  : lane_mant[LANE_EXT];
   assign rnd_carry = (prec == PREC_SGL) ? lane_carry[LANE_SGL] : lane_carry[LANE_EXT];

   // exponent: sum, bias removal, normalization and rounding adjustments
   logic [EXT_W-1:0] exp_raw;

   assign exp_raw = EXT_W'(a_exp) + EXT_W'(b_exp) - EXT_W'(BIAS)
                  + EXT_W'(prod_shift) + EXT_W'(rnd_carry);

   // range limiting and special zero
   logic [WORD_W-1:0] res_word;
   logic              res_uf;
   logic              res_ov;

   fpx_range #(
      .EXP_W    (EXP_W),
      .MANT_W   (MANT_W),
      .NARROW_W (NARROW_W)
   ) u_range (
      .sign_i   (a_sign ^ b_sign),
      .exp_i    (exp_raw),
      .mant_i   (rnd_mant),
      .narrow_i (prec == PREC_SGL),
      .zero_i   (zero_in),
      .word_o   (res_word),
      .uf_o     (res_uf),
      .ov_o     (res_ov)
   );

   // output stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         underflow <= 1'b0;
         overflow  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= res_word;
            underflow <= res_uf;
            overflow  <= res_ov;
         end
      end
   end

   // R10: a request gives a strobe one clock later
   a_r10_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R10: no request, no strobe, and the outputs hold
   a_r10_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(underflow) && $stable(overflow)));

   // R1: sign of the result follows the operand signs
   a_r1_sign : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (result[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1])));

   // R7: a flushed result has no magnitude
   a_r7_flush_zero : assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> (result[WORD_W-2:0] == '0));

   // R8: a saturated result carries the largest finite exponent
   a_r8_sat_exp : assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (result[WORD_W-2 -: EXP_W] == EMAX_F));

   // R5: single-mode results leave the low mantissa bits clear
   a_r5_low_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && prec_single) |=> (result[MANT_W-NARROW_W-1:0] == '0));

   // R9: a zero mantissa operand gives a clean zero without flags
   a_r9_zero_operand : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ((op_a[MANT_W-1:0] == '0) || (op_b[MANT_W-1:0] == '0)))
      |=> (result[WORD_W-2:0] == '0 && !underflow && !overflow));

endmodule

// File: tb/fpx_mul_bench.sv
module fpx_mul_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [43:0] op_a = '0;
   logic [43:0] op_b = '0;
   logic        prec_single = 1'b0;

   logic        out_valid, underflow, overflow;
   logic [43:0] result;
   logic        n_valid, n_uf, n_ov;
   logic [43:0] n_result;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fpx_mul u_fpx_mul (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .prec_single(prec_single), .out_valid(out_valid), .result(result),
      .underflow(underflow), .overflow(overflow)
   );

   fpx_mul #(.NARROW_W(16)) u_fpx_mul_n16 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .prec_single(prec_single), .out_valid(n_valid), .result(n_result),
      .underflow(n_uf), .overflow(n_ov)
   );

   task automatic check(input string tag, input logic [45:0] got, input logic [45:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // reference: returns {underflow, overflow, word}
   function automatic void ref_mul(input logic [43:0] a, input logic [43:0] b,
                                   input bit nar, input int kn,
                                   output logic [45:0] res, output string tag);
      logic [63:0] p;
      logic [32:0] keep;
      logic [31:0] m;
      int e, k;
      bit s, g, st;
      s   = a[43] ^ b[43];
      tag = nar ? "R5" : "R4";
      if (a[31:0] == 0 || b[31:0] == 0) begin
         res = {2'b00, s, 43'd0};
         tag = "R9";
         return;
      end
      p = {32'd0, a[31:0]} * {32'd0, b[31:0]};
      e = int'(a[42:32]) + int'(b[42:32]) - 1023;
      if (p[63]) e++;
      else p = p << 1;
      k = nar ? kn : 32;
      keep = 33'(p >> (64 - k));
      g  = p[63-k];
      st = (p & ((64'd1 << (63 - k)) - 64'd1)) != 0;
      if (g && (st || keep[0])) keep++;
      if (keep == (33'd1 << k)) begin
         keep = 33'd1 << (k - 1);
         e++;
         tag = "R6";
      end
      m = 32'(keep << (32 - k));
      if (e < 1) begin
         res = {2'b10, s, 43'd0};
         tag = "R7";
      end else if (e > 2046) begin
         m   = 32'((((33'd1 << k) - 33'd1)) << (32 - k));
         res = {2'b01, s, 11'd2046, m};
         tag = "R8";
      end else begin
         res = {2'b00, s, 11'(e), m};
      end
   endfunction

   logic [45:0] last_main;
   logic [45:0] last_n16;

   // one request; both instances checked against the reference, main one optionally to a literal
   task automatic run(input logic [43:0] a, input logic [43:0] b, input bit nar,
                      input string ltag, input bit use_lit, input logic [45:0] lit);
      logic [45:0] em, en;
      string tm, tn;
      ref_mul(a, b, nar, 24, em, tm);
      ref_mul(a, b, nar, 16, en, tn);
      @(negedge clk);
      op_a = a; op_b = b; prec_single = nar; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 strobe", {45'd0, out_valid}, 46'd1);
      if (use_lit) check(ltag, {underflow, overflow, result}, lit);
      else         check(tm,   {underflow, overflow, result}, em);
      check({tn, " n16"}, {n_uf, n_ov, n_result}, en);
      last_main = {underflow, overflow, result};
      last_n16  = {n_uf, n_ov, n_result};
   endtask

   function automatic logic [43:0] fp(input bit s, input int e, input logic [31:0] m);
      return {s, 11'(e), m};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 reset", {out_valid, underflow, overflow, result}, 47'd0);
      rst_n = 1'b1;

      // directed corners with literal expectations
      run(fp(0,1023,32'h80000000), fp(0,1023,32'h80000000), 0, "R2 one",   1, {2'b00, fp(0,1023,32'h80000000)});
      run(fp(1,1023,32'h80000000), fp(0,1023,32'h80000000), 0, "R1 sign",  1, {2'b00, fp(1,1023,32'h80000000)});
      run(fp(1,1000,32'hC0000000), fp(1,1050,32'hC0000000), 0, "R3 shift", 1, {2'b00, fp(0,1028,32'h90000000)});
      run(fp(0,1023,32'h80000080), fp(0,1023,32'h80000000), 1, "R5 tie even down", 1, {2'b00, fp(0,1023,32'h80000000)});
      run(fp(0,1023,32'h80000180), fp(0,1023,32'h80000000), 1, "R5 tie odd up",    1, {2'b00, fp(0,1023,32'h80000200)});
      run(fp(0,1023,32'h80000001), fp(0,1023,32'h80000000), 0, "R4 exact wide",    1, {2'b00, fp(0,1023,32'h80000001)});
      run(fp(0,1023,32'hFFFFFFFF), fp(0,1023,32'h80000000), 1, "R6 carry",  1, {2'b00, fp(0,1024,32'h80000000)});
      run(fp(1,1,32'h80000000),    fp(0,1,32'h80000000),    0, "R7 flush",  1, {2'b10, fp(1,0,32'h0)});
      run(fp(0,0,32'h80000000),    fp(0,1023,32'h80000000), 0, "R7 edge 0", 1, {2'b10, fp(0,0,32'h0)});
      run(fp(0,1,32'h80000000),    fp(0,1023,32'h80000000), 0, "R7 edge 1", 1, {2'b00, fp(0,1,32'h80000000)});
      run(fp(0,2046,32'h80000000), fp(0,1023,32'h80000000), 0, "R8 edge",   1, {2'b00, fp(0,2046,32'h80000000)});
      run(fp(0,2046,32'hC0000000), fp(0,1023,32'hC0000000), 0, "R8 shift over", 1, {2'b01, fp(0,2046,32'hFFFFFFFF)});
      run(fp(1,2046,32'h80000000), fp(0,2046,32'h80000000), 1, "R8 narrow sat", 1, {2'b01, fp(1,2046,32'hFFFFFF00)});
      run(fp(1,2046,32'h00000000), fp(0,2046,32'h80000000), 0, "R9 zero",  1, {2'b00, fp(1,0,32'h0)});

      // R10: idle cycle with new operands changes nothing
      @(negedge clk);
      op_a = fp(0,1100,32'hA5A5A5A5); op_b = fp(1,900,32'h9999AAAA); in_valid = 1'b0;
      @(negedge clk);
      check("R10 idle strobe", {45'd0, out_valid}, 46'd0);
      check("R10 idle hold",   {underflow, overflow, result}, last_main);
      check("R10 idle hold n16", {n_uf, n_ov, n_result}, last_n16);

      // constrained random
      void'($urandom(32'd20240611));
      for (int i = 0; i < 400; i++) begin
         logic [43:0] a, b;
         logic [31:0] ma, mb;
         int ea, eb, cls;
         cls = int'($urandom % 8);
         if (cls < 5)       begin ea = 973 + int'($urandom % 100); eb = 973 + int'($urandom % 100); end
         else if (cls == 5) begin ea = 1500 + int'($urandom % 547); eb = 1000 + int'($urandom % 547); end
         else if (cls == 6) begin ea = int'($urandom % 500); eb = 500 + int'($urandom % 100); end
         else               begin ea = int'($urandom % 2047); eb = int'($urandom % 2047); end
         ma = {1'b1, 31'($urandom)};
         mb = {1'b1, 31'($urandom)};
         if ($urandom % 4 == 0) ma = ma & ~32'((64'd1 << ($urandom % 30)) - 1);
         if ($urandom % 4 == 0) mb = mb & 32'hFFFF0000;
         if ($urandom % 8 == 0) ma = 32'hFFFFFFFF;
         if ($urandom % 32 == 0) mb = 32'd0;
         a = fp(1'($urandom), ea, ma);
         b = fp(1'($urandom), eb, mb);
         run(a, b, 1'($urandom), "", 0, 46'd0);
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule